// File: doc/BRIEF.md
# Integer Compare and Flag Unit

This unit evaluates one of ten integer relations between two operands and records the outcome in a single condition flag. The relations are equality, inequality, and greater-than, greater-or-equal, less-than and less-or-equal, each available in a signed and an unsigned form. The pipeline presents the operands, a condition code and a valid strobe. On the next rising clock edge the flag takes the result of the compare.

The flag drives a conditional-move selector. This combinational path returns the first operand while the flag is 1 and the second operand while it is 0. A branch unit elsewhere in the core reads the flag through `flag_o`.

A single subtraction computes equality, unsigned less-than and signed less-than, and the ten relations are derived from those three terms. The parameter `SUB_CMP` replaces the subtraction with separate comparators.

Top module: `cmp_flag_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, `flag_o` is 0 until the first accepted compare.
- R2: Code 0 (equal) sets the flag when `op_a_i == op_b_i`. Code 1 (not-equal) sets it when the operands differ.
- R3: Codes 2, 3, 4 and 5 compare the operands as unsigned magnitudes, in the order greater-than, greater-or-equal, less-than, less-or-equal of `op_a_i` against `op_b_i`.
- R4: Codes 6, 7, 8 and 9 compare the operands as two's-complement values, in the same order of relations as R3.
- R5: A compare with `cmp_valid_i` high and a code from 0 to 9 always writes the flag. The flag becomes 1 when the relation holds and 0 when it does not, whatever its previous value.
- R6: While `cmp_valid_i` is low, the flag keeps its value.
- R7: Codes 10 to 15 leave the flag unchanged, even when `cmp_valid_i` is high.
- R8: `cmov_o` equals `op_a_i` when `flag_o` is 1 and `op_b_i` when `flag_o` is 0, in the same cycle.
- R9: A compare result appears on `flag_o` after the rising edge at which the compare was presented, and not before.
- R10: For the operand pair 0x7FFFFFFF and 0x80000000, each signed relation returns the opposite result of its unsigned counterpart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Perform the compare at the next rising edge |
| cond_i | input | 4 | Condition code, see R2 to R4 and R7 |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| flag_o | output | 1 | Registered condition flag |
| cmov_o | output | WIDTH | Conditional-move result |

## Verification
The flag is the only state in the unit. If it is wrong, `flag_o` shows it one edge after the faulty compare, and `cmov_o` selects the wrong operand in the same cycle. A fault that swaps the signed and unsigned relations appears only when the operand signs differ, so the fixed pair 0x7FFFFFFF / 0x80000000 is applied with every code. A flag that is wrongly held or wrongly written appears at the first compare whose result differs from the old value. The random stimulus therefore mixes idle cycles, reserved codes and legal compares, and checks each one after the next edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [3:0] {
    COND_EQ  = 4'd0,
    COND_NE  = 4'd1,
    COND_GTU = 4'd2,
    COND_GEU = 4'd3,
    COND_LTU = 4'd4,
    COND_LEU = 4'd5,
    COND_GTS = 4'd6,
    COND_GES = 4'd7,
    COND_LTS = 4'd8,
    COND_LES = 4'd9
  } cond_e;

  localparam int unsigned COND_LAST = 9;

  typedef struct packed {
    logic eq;
    logic ltu;
    logic lts;
  } cmp_rel_t;
endpackage

// File: rtl/cmp_core.sv
module cmp_core
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter bit          SUB_CMP = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output cmp_rel_t         rel_o
);
  localparam int unsigned MSB = WIDTH - 1;

  generate
    if (SUB_CMP) begin : g_sub
      logic [WIDTH:0] diff;
      logic           sign_diff;
      assign diff      = {1'b0, a_i} - {1'b0, b_i};
      assign sign_diff = a_i[MSB] ^ b_i[MSB];
      assign rel_o.eq  = (diff[MSB:0] == '0);
      assign rel_o.ltu = diff[WIDTH];
      // with equal signs the difference cannot overflow
      assign rel_o.lts = sign_diff ? a_i[MSB] : diff[MSB];
    end else begin : g_direct
      assign rel_o.eq  = (a_i == b_i);
      assign rel_o.ltu = (a_i < b_i);
      assign rel_o.lts = ($signed(a_i) < $signed(b_i));
    end
  endgenerate
endmodule

// File: rtl/cmp_cond_sel.sv
module cmp_cond_sel
  import cmp_pkg::*;
(
  input  logic [3:0] cond_i,
  input  cmp_rel_t   rel_i,
  output logic       hit_o,
  output logic       legal_o
);
  always_comb begin
    hit_o   = 1'b0;
    legal_o = 1'b1;
    case (cond_i)
      COND_EQ:  hit_o = rel_i.eq;
      COND_NE:  hit_o = !rel_i.eq;
      COND_GTU: hit_o = !rel_i.ltu && !rel_i.eq;
      COND_GEU: hit_o = !rel_i.ltu;
      COND_LTU: hit_o = rel_i.ltu;
      COND_LEU: hit_o = rel_i.ltu || rel_i.eq;
      COND_GTS: hit_o = !rel_i.lts && !rel_i.eq;
      COND_GES: hit_o = !rel_i.lts;
      COND_LTS: hit_o = rel_i.lts;
      COND_LES: hit_o = rel_i.lts || rel_i.eq;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter bit          SUB_CMP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic [3:0]       cond_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic             flag_o,
  output logic [WIDTH-1:0] cmov_o
);
  localparam int unsigned MSB = WIDTH - 1;

  cmp_rel_t rel;
  logic     hit, legal, flag_we, flag_q;

  cmp_core #(.WIDTH(WIDTH), .SUB_CMP(SUB_CMP)) u_core (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .rel_o (rel)
  );

  cmp_cond_sel u_sel (
    .cond_i  (cond_i),
    .rel_i   (rel),
    .hit_o   (hit),
    .legal_o (legal)
  );

  assign flag_we = cmp_valid_i && legal;

  cmp_flag_reg u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we),
    .d_i    (hit),
    .q_o    (flag_q)
  );

  assign flag_o = flag_q;
  assign cmov_o = flag_q ? op_a_i : op_b_i;

  // R2
  eq_excludes_lt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel.eq |-> (!rel.ltu && !rel.lts));

  // R10
  sign_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i[MSB] == op_b_i[MSB]) |-> (rel.ltu == rel.lts));

  // R10
  sign_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_a_i[MSB] != op_b_i[MSB]) && !rel.eq) |-> (rel.ltu != rel.lts));

  // R5
  flag_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && (cond_i <= 4'(COND_LAST))) |=> (flag_o == $past(hit)));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> $stable(flag_o));

  // R7
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i > 4'(COND_LAST)) |=> $stable(flag_o));
endmodule

// File: tb/cmp_flag_unit_tb.sv
module cmp_flag_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic [3:0]   cond = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         flag;
  logic [W-1:0] cmov;

  int errors = 0;
  int checks = 0;
  logic model = 1'b0;

  always #2.5 clk = ~clk;

  cmp_flag_unit #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(vld), .cond_i(cond),
    .op_a_i(a), .op_b_i(b), .flag_o(flag), .cmov_o(cmov)
  );

  function automatic logic rel_holds(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    case (c)
      4'd0: return x == y;
      4'd1: return x != y;
      4'd2: return x > y;
      4'd3: return x >= y;
      4'd4: return x < y;
      4'd5: return x <= y;
      4'd6: return $signed(x) > $signed(y);
      4'd7: return $signed(x) >= $signed(y);
      4'd8: return $signed(x) < $signed(y);
      4'd9: return $signed(x) <= $signed(y);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic v, input logic [3:0] c);
    if (!v) return "R6";
    if (c < 2) return "R2";
    if (c < 6) return "R3";
    if (c < 10) return "R4";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmp(input logic v, input logic [3:0] c, input logic [W-1:0] x,
                        input logic [W-1:0] y, input string req);
    @(negedge clk);
    vld = v; cond = c; a = x; b = y;
    #1;
    // R9: nothing visible before the edge
    check("R9", {31'b0, flag}, {31'b0, model});
    if (v && c <= 4'd9) model = rel_holds(c, x, y);
    @(negedge clk);
    vld = 1'b0;
    check(req, {31'b0, flag}, {31'b0, model});
    // R8
    check("R8", cmov, model ? x : y);
  endtask

  initial begin
    #500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    a = 32'h1234_5678; b = 32'h9abc_def0;
    #12;
    // R1
    check("R1", {31'b0, flag}, 32'd0);
    check("R8", cmov, b);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, flag}, 32'd0);

    // R2 directed
    do_cmp(1, 4'd0, 32'd5, 32'd5, "R2");
    do_cmp(1, 4'd1, 32'd5, 32'd5, "R2");
    do_cmp(1, 4'd1, 32'd5, 32'd6, "R2");
    // R5: set then clear with the same code
    do_cmp(1, 4'd4, 32'd1, 32'd2, "R5");
    do_cmp(1, 4'd4, 32'd2, 32'd1, "R5");
    do_cmp(1, 4'd5, 32'd7, 32'd7, "R5");
    // R6 / R7 hold a set flag
    do_cmp(0, 4'd0, 32'd1, 32'd9, "R6");
    do_cmp(1, 4'd12, 32'd1, 32'd9, "R7");
    do_cmp(1, 4'd15, 32'd0, 32'd0, "R7");
    // R10: every code at the disagreement pair, both orders
    for (int c = 0; c < 10; c++) begin
      do_cmp(1, 4'(c), 32'h7fff_ffff, 32'h8000_0000, "R10");
      do_cmp(1, 4'(c), 32'h8000_0000, 32'h7fff_ffff, "R10");
    end
    // R3 / R4 extremes
    do_cmp(1, 4'd2, 32'hffff_ffff, 32'd0, "R3");
    do_cmp(1, 4'd6, 32'hffff_ffff, 32'd0, "R4");
    do_cmp(1, 4'd9, 32'h8000_0000, 32'h8000_0000, "R4");

    for (int i = 0; i < 400; i++) begin
      logic v;
      logic [3:0] c;
      logic [W-1:0] x, y;
      v = ($urandom % 5) != 0;
      c = 4'($urandom % 16);
      x = $urandom;
      case ($urandom % 4)
        0: y = x;
        1: y = x ^ 32'h8000_0000;
        default: y = $urandom;
      endcase
      do_cmp(v, c, x, y, tag_of(v, c));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule